// File: doc/BRIEF.md
# Programmable Lookup Cell Array

This block is a regular two-dimensional array of identical logic cells. Each cell has one input bit from each of its four neighbours (north, east, south, west) and drives one output bit back towards each of them. Every output bit has its own 16-entry lookup table indexed by the four input bits, so one cell can compute four different Boolean functions of the same inputs. Along the array boundary, the inputs and outputs that have no neighbour become the block's external pins. Signals travel only between adjacent cells, so there is no long wire anywhere in the fabric.

A host loads all tables and the per-output timing bits through a plain write port, as if the array were a small memory. Each cell's configuration is written four bits at a time. Each output can run in one of two modes. In live mode the table result goes straight through as combinational logic. In staged mode the result is held in a register that captures only on one of two phase strobes. The phase is chosen by the cell's checkerboard colour, so data moving through staged cells advances one cell per strobe.

Top module: `lg_array`

## Requirements
- R1: After a synchronous reset, every edge output is 0 whatever the edge inputs are.
- R2: The output of a cell in direction d equals bit i of that output's table. The index i is {north_in, east_in, south_in, west_in}, with north_in as the most significant bit. In live mode the output follows input changes within the same cycle.
- R3: The config write address is {cell_y, cell_x, nibble}, with a 5-bit nibble field. Nibble k (0 to 15) loads bits [4*(k%4)+3 : 4*(k%4)] of the table for direction k/4. Directions are numbered north=0, east=1, south=2, west=3. Nibble 16 loads the four mode bits, where bit d is the mode of output d and 1 means staged.
- R4: A write to nibble 17 to 31, or to a cell coordinate outside the array, changes no configuration.
- R5: A config write takes effect on the clock edge that samples it, and not before.
- R6: A staged output holds the value its register took at the last capture. Cells whose (x+y) is even capture on phase_a, and cells whose (x+y) is odd capture on phase_b. With no strobe, the output does not change.
- R7: Reset clears all tables to 0, sets all outputs to live mode and clears every stage register.
- R8: Each output is wired to the opposite-side input of the adjacent cell. Row 0 is the north edge and column 0 is the west edge. Edge pins are indexed by column for north and south, and by row for east and west.
- R9: In a chain of staged cells, a value advances by one cell for each phase strobe that matches the next cell's parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | Y_W+X_W+5 | Write address {cell_y, cell_x, nibble} |
| cfg_data | input | 4 | Nibble to write |
| phase_a | input | 1 | Capture strobe for even-parity cells |
| phase_b | input | 1 | Capture strobe for odd-parity cells |
| edge_n_in | input | GRID_W | North inputs of row 0, one per column |
| edge_e_in | input | GRID_H | East inputs of the last column, one per row |
| edge_s_in | input | GRID_W | South inputs of the last row, one per column |
| edge_w_in | input | GRID_H | West inputs of column 0, one per row |
| edge_n_out | output | GRID_W | North outputs of row 0 |
| edge_e_out | output | GRID_H | East outputs of the last column |
| edge_s_out | output | GRID_W | South outputs of the last row |
| edge_w_out | output | GRID_H | West outputs of column 0 |

## Verification
The bench builds the array with 4 columns and 3 rows. Because the row count is not a power of two, row address 3 is a hole in the address space. A write to that hole is shown to leave the array alone. The 4-column chain holds cells of both parities, so the phase_a and phase_b capture groups alternate along one row, and the bench can follow a value hop by hop against its own model. Writes routed down a column and a mixed XOR row exercise wiring in three directions, not only the main chain.

// File: rtl/lg_pkg.sv
package lg_pkg;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    localparam int NIB_W    = 5;
    localparam int LUT_BITS = 16;
    localparam int NDIR     = 4;
    localparam logic [NIB_W-1:0] MODE_NIB = 5'd16;

    typedef struct packed {
        logic [NDIR-1:0][LUT_BITS-1:0] lut;
        logic [NDIR-1:0]               mode;
    } cell_cfg_t;

    function automatic logic [3:0] lut_index(input logic [NDIR-1:0] nbr);
        return {nbr[DIR_N], nbr[DIR_E], nbr[DIR_S], nbr[DIR_W]};
    endfunction

    function automatic bit odd_site(input int x, input int y);
        return ((x + y) % 2) == 1;
    endfunction

endpackage

// File: rtl/lg_cell_cfg.sv
module lg_cell_cfg
    import lg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [NIB_W-1:0] nib_i,
    input  logic [3:0]       data_i,
    output cell_cfg_t        cfg_o
);

    cell_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we_i) begin
            if (nib_i < MODE_NIB) begin
                cfg_q.lut[nib_i[3:2]][{nib_i[1:0], 2'b00} +: 4] <= data_i;
            end else if (nib_i == MODE_NIB) begin
                cfg_q.mode <= data_i;
            end
        end
    end

    assign cfg_o = cfg_q;

    // R4
    bad_nib_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && nib_i > MODE_NIB) |=> $stable(cfg_q));

    // R3
    mode_nib_load_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && nib_i == MODE_NIB) |=> (cfg_q.mode == $past(data_i)));

    // R7
    cfg_reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cfg_q == '0));

endmodule

// File: rtl/lg_out_stage.sv
module lg_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic lut_bit_i,
    input  logic mode_i,
    input  logic cap_en_i,
    output logic bit_o
);

    logic cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
        end else if (cap_en_i) begin
            cap_q <= lut_bit_i;
        end
    end

    assign bit_o = mode_i ? cap_q : lut_bit_i;

    // R6
    staged_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !cap_en_i) |=> (!mode_i || $stable(bit_o)));

    // R6
    staged_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i && cap_en_i) |=> (!mode_i || bit_o == $past(lut_bit_i)));

endmodule

// File: rtl/lg_cell.sv
module lg_cell
    import lg_pkg::*;
#(
    parameter bit ODD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we_i,
    input  logic [NIB_W-1:0] cfg_nib_i,
    input  logic [3:0]       cfg_data_i,
    input  logic             cap_a_i,
    input  logic             cap_b_i,
    input  logic [NDIR-1:0]  nbr_i,
    output logic [NDIR-1:0]  nbr_o
);

    cell_cfg_t  cfg;
    logic [3:0] idx;
    logic       cap_en;

    lg_cell_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cfg_we_i),
        .nib_i  (cfg_nib_i),
        .data_i (cfg_data_i),
        .cfg_o  (cfg)
    );

    assign idx    = lut_index(nbr_i);
    assign cap_en = ODD ? cap_b_i : cap_a_i;

    for (genvar d = 0; d < NDIR; d++) begin : g_out
        lg_out_stage u_stage (
            .clk       (clk),
            .rst       (rst),
            .lut_bit_i (cfg.lut[d][idx]),
            .mode_i    (cfg.mode[d]),
            .cap_en_i  (cap_en),
            .bit_o     (nbr_o[d])
        );
    end

endmodule

// File: rtl/lg_array.sv
module lg_array
    import lg_pkg::*;
#(
    parameter  int GRID_W = 4,
    parameter  int GRID_H = 3,
    localparam int X_W    = (GRID_W > 1) ? $clog2(GRID_W) : 1,
    localparam int Y_W    = (GRID_H > 1) ? $clog2(GRID_H) : 1,
    localparam int ADDR_W = Y_W + X_W + NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_data,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic [GRID_W-1:0] edge_n_in,
    input  logic [GRID_H-1:0] edge_e_in,
    input  logic [GRID_W-1:0] edge_s_in,
    input  logic [GRID_H-1:0] edge_w_in,
    output logic [GRID_W-1:0] edge_n_out,
    output logic [GRID_H-1:0] edge_e_out,
    output logic [GRID_W-1:0] edge_s_out,
    output logic [GRID_H-1:0] edge_w_out
);

    logic [Y_W-1:0]   cfg_y;
    logic [X_W-1:0]   cfg_x;
    logic [NIB_W-1:0] cfg_nib;

    assign cfg_y   = cfg_addr[ADDR_W-1 -: Y_W];
    assign cfg_x   = cfg_addr[NIB_W +: X_W];
    assign cfg_nib = cfg_addr[NIB_W-1:0];

    logic [NDIR-1:0] cin  [GRID_H][GRID_W];
    logic [NDIR-1:0] cout [GRID_H][GRID_W];

    for (genvar gy = 0; gy < GRID_H; gy++) begin : g_y
        for (genvar gx = 0; gx < GRID_W; gx++) begin : g_x
            logic nb, eb, sb, wb;
            logic sel;

            if (gy == 0) begin : g_n_edge
                assign nb = edge_n_in[gx];
            end else begin : g_n_link
                assign nb = cout[gy-1][gx][DIR_S];
            end

            if (gx == GRID_W-1) begin : g_e_edge
                assign eb = edge_e_in[gy];
            end else begin : g_e_link
                assign eb = cout[gy][gx+1][DIR_W];
            end

            if (gy == GRID_H-1) begin : g_s_edge
                assign sb = edge_s_in[gx];
            end else begin : g_s_link
                assign sb = cout[gy+1][gx][DIR_N];
            end

            if (gx == 0) begin : g_w_edge
                assign wb = edge_w_in[gy];
            end else begin : g_w_link
                assign wb = cout[gy][gx-1][DIR_E];
            end

            assign cin[gy][gx] = {wb, sb, eb, nb};
            assign sel = cfg_we && (cfg_y == Y_W'(gy)) && (cfg_x == X_W'(gx));

            lg_cell #(
                .ODD (odd_site(gx, gy))
            ) u_cell (
                .clk        (clk),
                .rst        (rst),
                .cfg_we_i   (sel),
                .cfg_nib_i  (cfg_nib),
                .cfg_data_i (cfg_data),
                .cap_a_i    (phase_a),
                .cap_b_i    (phase_b),
                .nbr_i      (cin[gy][gx]),
                .nbr_o      (cout[gy][gx])
            );
        end
    end

    for (genvar gx = 0; gx < GRID_W; gx++) begin : g_ns_pins
        assign edge_n_out[gx] = cout[0][gx][DIR_N];
        assign edge_s_out[gx] = cout[GRID_H-1][gx][DIR_S];
    end

    for (genvar gy = 0; gy < GRID_H; gy++) begin : g_ew_pins
        assign edge_w_out[gy] = cout[gy][0][DIR_W];
        assign edge_e_out[gy] = cout[gy][GRID_W-1][DIR_E];
    end

    // R1
    reset_quiet_edges_chk: assert property (@(posedge clk)
        rst |=> (edge_n_out == '0 && edge_e_out == '0 &&
                 edge_s_out == '0 && edge_w_out == '0));

endmodule

// File: tb/lg_array_bench.sv
`timescale 1ns/1ps
module lg_array_bench;

    localparam int GW = 4;
    localparam int GH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [3:0]  cfg_data = '0;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic [GW-1:0] n_in = '0, s_in = '0, n_out, s_out;
    logic [GH-1:0] e_in = '0, w_in = '0, e_out, w_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lg_array #(.GRID_W(GW), .GRID_H(GH)) u_lg_array (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .phase_a(phase_a), .phase_b(phase_b),
        .edge_n_in(n_in), .edge_e_in(e_in), .edge_s_in(s_in), .edge_w_in(w_in),
        .edge_n_out(n_out), .edge_e_out(e_out), .edge_s_out(s_out), .edge_w_out(w_out)
    );

    // {s3, w2, w1, w0, exp_e[2:0], exp_n[3:0]}
    localparam logic [10:0] VEC [8] = '{
        {4'b0000, 3'b000, 4'b0000},
        {4'b0001, 3'b000, 4'b0000},
        {4'b0010, 3'b010, 4'b0001},
        {4'b0100, 3'b100, 4'b0000},
        {4'b1000, 3'b100, 4'b0000},
        {4'b1100, 3'b000, 4'b0000},
        {4'b1110, 3'b010, 4'b0001},
        {4'b0111, 3'b110, 4'b0001}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int y, input int x, input int nib, input logic [3:0] d);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = {2'(y), 2'(x), 5'(nib)};
        cfg_data = d;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic wr_lut(input int y, input int x, input int dir, input logic [15:0] t);
        for (int k = 0; k < 4; k++) wr(y, x, dir*4 + k, t[4*k +: 4]);
    endtask

    task automatic run_vectors(input string tag);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            s_in[3] = VEC[i][10];
            w_in    = VEC[i][9:7];
            #1;
            // R2 R8: live chain, XOR row and column path
            check(e_out == VEC[i][6:4], {tag, " R2 east"}, 32'(e_out), 32'(VEC[i][6:4]));
            check(n_out == VEC[i][3:0], {tag, " R8 north"}, 32'(n_out), 32'(VEC[i][3:0]));
        end
    endtask

    initial begin
        #900000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic r [4];
        logic nr [4];
        n_in = '1; e_in = '1; s_in = '1; w_in = '1;
        repeat (3) @(negedge clk);
        // R1 R7
        check(n_out == 0 && e_out == 0 && s_out == 0 && w_out == 0, "R1 reset edges",
              {n_out, e_out, s_out, w_out}, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        check(n_out == 0 && e_out == 0 && s_out == 0 && w_out == 0, "R7 zero cfg",
              {n_out, e_out, s_out, w_out}, 0);
        n_in = '0; e_in = '0; s_in = '0; w_in = '0;

        // R3: row 1 east = !west; row 2 east buffers then XOR with south; column 0 upward
        for (int x = 0; x < 4; x++) wr_lut(1, x, 1, 16'h5555);
        for (int x = 0; x < 3; x++) wr_lut(2, x, 1, 16'hAAAA);
        wr_lut(2, 3, 1, 16'h6666);
        wr_lut(1, 0, 0, 16'hAAAA);
        wr_lut(0, 0, 0, 16'hCCCC);
        run_vectors("first");

        // R4: nibble above 16 and row outside the array
        wr(1, 0, 20, 4'h0);
        wr(1, 0, 31, 4'hF);
        wr(3, 0, 0, 4'hF);
        run_vectors("after ignored writes R4");

        // R6 R9: stage row 1 east outputs, software model of the chain
        for (int x = 0; x < 4; x++) wr(1, x, 16, 4'b0010);
        for (int x = 0; x < 4; x++) r[x] = 1'b0;
        @(negedge clk); #1;
        check(e_out[1] == 1'b0, "R6 staged after reset", 32'(e_out[1]), 0);
        for (int k = 0; k < 18; k++) begin
            int sel;
            sel = k % 3;
            @(negedge clk);
            w_in[1] = ((k / 5) % 2) == 0;
            phase_a = (sel == 0);
            phase_b = (sel == 1);
            for (int x = 0; x < 4; x++) nr[x] = r[x];
            for (int x = 0; x < 4; x++) begin
                bit odd;
                odd = ((x + 1) % 2) == 1;
                if ((odd && sel == 1) || (!odd && sel == 0))
                    nr[x] = !(x == 0 ? w_in[1] : r[x-1]);
            end
            @(negedge clk);
            phase_a = 1'b0;
            phase_b = 1'b0;
            for (int x = 0; x < 4; x++) r[x] = nr[x];
            #1;
            check(e_out[1] == r[3], "R9 staged chain hop", 32'(e_out[1]), 32'(r[3]));
        end

        // R6: no strobe, input flips, output holds
        @(negedge clk);
        w_in[1] = ~w_in[1];
        repeat (3) @(negedge clk);
        #1;
        check(e_out[1] == r[3], "R6 hold without strobe", 32'(e_out[1]), 32'(r[3]));

        // R5: write lands on the edge, not before
        @(negedge clk);
        w_in = '0;
        #1;
        check(n_out[0] == 1'b0, "R5 before write", 32'(n_out[0]), 0);
        cfg_we   = 1'b1;
        cfg_addr = {2'd0, 2'd0, 5'd0};
        cfg_data = 4'hF;
        #1;
        check(n_out[0] == 1'b0, "R5 write pending", 32'(n_out[0]), 0);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(n_out[0] == 1'b1, "R5 after edge", 32'(n_out[0]), 1);

        // R7: reset clears tables and stage registers
        @(negedge clk);
        rst = 1'b1;
        w_in = '1; s_in = '1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check(n_out == 0 && e_out == 0, "R7 cleared after reset", {n_out, e_out}, 0);
        phase_a = 1'b1; phase_b = 1'b1;
        @(negedge clk);
        phase_a = 1'b0; phase_b = 1'b0;
        #1;
        check(e_out == 0 && s_out == 0 && w_out == 0, "R7 live zero tables",
              {e_out, s_out, w_out}, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule